// File: doc/BRIEF.md
# Saturating Wide Adder With Write-Word Formatter

This block is one datapath stage that forms the sum of two 37-bit two's-complement operands, clamps that sum into the 32-bit signed range when clamping is switched on, and then moves the selected 32-bit value into one of four byte lanes of a memory write word. The whole chain from operand inputs to write word is one combinational path. The only storage is an optional register on the outputs, selected by a parameter.

The clamp decision does not use overflow flags from the adder. It uses two bit reductions over the sum. The band runs from the bit just below the sign down to the top bit of the 32-bit result. If the sign is clear and any band bit is set, the sum is above the largest 32-bit signed value. If the sign is set and any band bit is clear, the sum is below the smallest one. The formatter then shifts left by a whole number of bytes, fills with zeros, and drops any bits shifted past bit 31.

Top module: `sat_add_fmt`

## Requirements
- R1: The sum is `op_a + op_b` taken modulo 2^37. With clamping off and format 0, `wr_word` equals bits 31..0 of that sum.
- R2: With `sat_en` = 1, if the sum is a positive number of 2^31 or more (bit 36 = 0 and any of bits 35..31 set), the selected value is 32'h7FFF_FFFF.
- R3: With `sat_en` = 1, if the sum is a negative number below -2^31 (bit 36 = 1 and any of bits 35..31 clear), the selected value is 32'h8000_0000.
- R4: A sum inside the signed 32-bit range, including exactly -2^31 and 2^31-1, passes bits 31..0 unchanged, even when `sat_en` = 1.
- R5: With `sat_en` = 0, no clamping takes place and `sat_flag` is 0, whatever the sum.
- R6: `sat_flag` is 1 exactly when the clamp of R2 or R3 replaced the sum. It appears in the same cycle as the word it belongs to.
- R7: `fmt` selects a left shift of 8*`fmt` bits: 0 gives 0 bits, 1 gives 8, 2 gives 16, 3 gives 24. Vacated low bits are 0 and bits shifted past bit 31 are dropped.
- R8: `out_valid` carries `in_valid` with the same latency as `wr_word`.
- R9: With `OUT_REG` = 1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` sets `wr_word`, `sat_flag` and `out_valid` to 0. With `OUT_REG` = 0 the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only by the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 37 | First two's-complement operand |
| op_b | input | 37 | Second two's-complement operand |
| sat_en | input | 1 | 1 enables clamping to the signed 32-bit range |
| fmt | input | 2 | Byte-lane shift selector (shift = 8*fmt) |
| in_valid | input | 1 | Input qualifier |
| wr_word | output | 32 | Formatted memory write word |
| sat_flag | output | 1 | 1 when a clamp constant replaced the sum |
| out_valid | output | 1 | Delayed copy of in_valid |

## Verification
The directed patterns sit on both sides of each clamp threshold. Sums of 2^31-1 and 2^31 separate a correct positive test from an off-by-one band. Sums of -2^31 and -2^31-1 do the same for the negative side. A carry out of bit 36 confirms that the sum wraps rather than widens. A positive overflow with clamping off shows that the enable really gates the clamp. A single pattern under all four formats, clamped and unclamped, shows that the lane shift drops high bits and fills with zeros. A long run of random operands, split between large magnitudes and small ones, is then compared every clock against a model that judges range with signed integer comparisons and uses no bit reductions.

// File: rtl/sat_fmt_pkg.sv
package sat_fmt_pkg;

    localparam int unsigned DEF_OP_W   = 37;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_STEP   = 8;
    localparam int unsigned DEF_SEL_W  = 2;

    // Outcome of the range check on the wide sum
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_POS  = 2'd1,
        CLAMP_NEG  = 2'd2
    } clamp_e;

    // Largest signed value of a w-bit word, placed in a DEF_WORD_W container
    function automatic logic [DEF_WORD_W-1:0] signed_max(input int unsigned w);
        logic [DEF_WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < int'(w) - 1; i++) r[i] = 1'b1;
        return r;
    endfunction

    // Smallest signed value of a w-bit word
    function automatic logic [DEF_WORD_W-1:0] signed_min(input int unsigned w);
        logic [DEF_WORD_W-1:0] r;
        r = '0;
        r[w-1] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sat_wide_add.sv
module sat_wide_add #(
    parameter int unsigned W = sat_fmt_pkg::DEF_OP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    // Carry out of the top bit is discarded: the sum wraps at 2^W
    always_comb sum_o = a_i + b_i;
endmodule

// File: rtl/sat_band_detect.sv
module sat_band_detect
    import sat_fmt_pkg::*;
#(
    parameter int unsigned W  = DEF_OP_W,
    parameter int unsigned HI = W - 2,
    parameter int unsigned LO = DEF_WORD_W - 1
) (
    input  logic [W-1:0] sum_i,
    input  logic         en_i,
    output clamp_e       kind_o
);
    logic sign_b;
    logic any_set;
    logic all_set;

    always_comb begin
        sign_b  = sum_i[W-1];
        any_set = |sum_i[HI:LO];
        all_set = &sum_i[HI:LO];
        kind_o  = CLAMP_NONE;
        if (en_i) begin
            if (!sign_b && any_set)     kind_o = CLAMP_POS;
            else if (sign_b && !all_set) kind_o = CLAMP_NEG;
        end
    end
endmodule

// File: rtl/word_lane_shift.sv
module word_lane_shift #(
    parameter int unsigned WORD_W = sat_fmt_pkg::DEF_WORD_W,
    parameter int unsigned STEP   = sat_fmt_pkg::DEF_STEP,
    parameter int unsigned SEL_W  = sat_fmt_pkg::DEF_SEL_W
) (
    input  logic [WORD_W-1:0] val_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [WORD_W-1:0] cand [NSEL];

    for (genvar k = 0; k < NSEL; k++) begin : g_lane
        assign cand[k] = val_i << (k * STEP);
    end

    always_comb word_o = cand[sel_i];
endmodule

// File: rtl/sat_add_fmt.sv
module sat_add_fmt
    import sat_fmt_pkg::*;
#(
    parameter int unsigned OP_W    = DEF_OP_W,
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned STEP    = DEF_STEP,
    parameter int unsigned SEL_W   = DEF_SEL_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              sat_en,
    input  logic [SEL_W-1:0]  fmt,
    input  logic              in_valid,
    output logic [WORD_W-1:0] wr_word,
    output logic              sat_flag,
    output logic              out_valid
);
    localparam int unsigned BAND_HI = OP_W - 2;
    localparam int unsigned BAND_LO = WORD_W - 1;
    localparam logic [WORD_W-1:0] MAX_C = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] MIN_C = {1'b1, {(WORD_W-1){1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sat;
        logic              valid;
    } stage_t;

    logic [OP_W-1:0]   sum;
    clamp_e            kind;
    logic [WORD_W-1:0] picked;
    logic [WORD_W-1:0] shaped;
    stage_t            nxt;
    stage_t            cur;

    sat_wide_add #(.W(OP_W)) u_add (
        .a_i   (op_a),
        .b_i   (op_b),
        .sum_o (sum)
    );

    sat_band_detect #(.W(OP_W), .HI(BAND_HI), .LO(BAND_LO)) u_det (
        .sum_i  (sum),
        .en_i   (sat_en),
        .kind_o (kind)
    );

    always_comb begin
        unique case (kind)
            CLAMP_POS: picked = MAX_C;
            CLAMP_NEG: picked = MIN_C;
            default:   picked = sum[WORD_W-1:0];
        endcase
    end

    word_lane_shift #(.WORD_W(WORD_W), .STEP(STEP), .SEL_W(SEL_W)) u_shift (
        .val_i  (picked),
        .sel_i  (fmt),
        .word_o (shaped)
    );

    always_comb begin
        nxt.word  = shaped;
        nxt.sat   = (kind != CLAMP_NONE);
        nxt.valid = in_valid;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end
    end else begin : g_comb
        always_comb cur = nxt;
    end

    assign wr_word   = cur.word;
    assign sat_flag  = cur.sat;
    assign out_valid = cur.valid;
endmodule

// File: rtl/sat_add_fmt_chk.sv
module sat_add_fmt_chk #(
    parameter int unsigned OP_W    = 37,
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned SEL_W   = 2,
    parameter bit          OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              sat_en,
    input logic [SEL_W-1:0]  fmt,
    input logic              in_valid,
    input logic [WORD_W-1:0] wr_word,
    input logic              sat_flag,
    input logic              out_valid
);
    logic [OP_W-1:0] full;
    logic            big_pos;
    assign full    = op_a + op_b;
    assign big_pos = !full[OP_W-1] && (full[OP_W-2:0] >= (1 << (WORD_W-1)));

    if (OUT_REG) begin : g_seq
        // R5
        no_flag_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            !sat_en |=> !sat_flag);
        // R8
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (out_valid == $past(in_valid)));
        // R1
        passthru_sum_chk: assert property (@(posedge clk) disable iff (rst)
            (!sat_en && fmt == '0) |=> (wr_word == $past(full[WORD_W-1:0])));
        // R2
        pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            (sat_en && fmt == '0 && big_pos) |=> (sat_flag && wr_word == {1'b0, {(WORD_W-1){1'b1}}}));
        // R7
        top_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (fmt == '1) |=> (wr_word[WORD_W-9:0] == '0));
        // R6
        flag_word_chk: assert property (@(posedge clk) disable iff (rst)
            (sat_en && fmt == '0) |=> (!sat_flag || wr_word == {1'b0, {(WORD_W-1){1'b1}}}
                                                  || wr_word == {1'b1, {(WORD_W-1){1'b0}}}));
    end else begin : g_comb
        // R5
        no_flag_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            !sat_en |-> !sat_flag);
        // R8
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
        // R2
        pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            (sat_en && fmt == '0 && big_pos) |-> (sat_flag && wr_word == {1'b0, {(WORD_W-1){1'b1}}}));
        // R1
        passthru_sum_chk: assert property (@(posedge clk) disable iff (rst)
            (!sat_en && fmt == '0) |-> (wr_word == full[WORD_W-1:0]));
    end
endmodule

bind sat_add_fmt sat_add_fmt_chk #(
    .OP_W(OP_W), .WORD_W(WORD_W), .SEL_W(SEL_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sat_en(sat_en),
    .fmt(fmt), .in_valid(in_valid), .wr_word(wr_word),
    .sat_flag(sat_flag), .out_valid(out_valid)
);

// File: tb/sat_add_fmt_test.sv
`timescale 1ns/1ps
module sat_add_fmt_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [36:0] op_a = '0;
    logic [36:0] op_b = '0;
    logic        sat_en = 1'b0;
    logic [1:0]  fmt = '0;
    logic        in_valid = 1'b0;
    logic [31:0] wr_word;
    logic        sat_flag;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_word;
    logic        exp_flag;
    logic        exp_valid;
    string       exp_tag;
    bit          pend = 0;

    always #10 clk = ~clk;

    sat_add_fmt uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sat_en(sat_en),
        .fmt(fmt), .in_valid(in_valid), .wr_word(wr_word),
        .sat_flag(sat_flag), .out_valid(out_valid)
    );

    // Behavioural reference: signed range test on integers
    function automatic void model(input logic [36:0] a, input logic [36:0] b,
                                  input logic en, input logic [1:0] f,
                                  output logic [31:0] w, output logic fl);
        logic [63:0] s;
        longint      v;
        logic [63:0] sel;
        s = ({27'd0, a} + {27'd0, b}) & 64'h1F_FFFF_FFFF;
        v = s[36] ? longint'(s) - (longint'(1) << 37) : longint'(s);
        fl = 1'b0;
        sel = s;
        if (en && v > 64'sd2147483647)       begin sel = 64'h7FFF_FFFF; fl = 1'b1; end
        else if (en && v < -64'sd2147483648) begin sel = 64'h8000_0000; fl = 1'b1; end
        w = 32'((sel << (8 * int'(f))) & 64'hFFFF_FFFF);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_pending();
        if (pend) begin
            check(exp_tag, "wr_word", wr_word, exp_word);
            check({exp_tag, " R6"}, "sat_flag", {31'd0, sat_flag}, {31'd0, exp_flag});
            check("R8", "out_valid", {31'd0, out_valid}, {31'd0, exp_valid});
        end
    endtask

    task automatic step(input logic [36:0] a, input logic [36:0] b, input logic en,
                        input logic [1:0] f, input logic v, input string tag);
        @(negedge clk);
        compare_pending();
        op_a = a; op_b = b; sat_en = en; fmt = f; in_valid = v;
        model(a, b, en, f, exp_word, exp_flag);
        exp_valid = v;
        exp_tag = tag;
        pend = 1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "reset wr_word", wr_word, 32'h0);
        check("R9", "reset sat_flag", {31'd0, sat_flag}, 32'h0);
        check("R9", "reset out_valid", {31'd0, out_valid}, 32'h0);
        rst = 1'b0;

        step(37'd5, 37'd7, 1'b1, 2'd0, 1'b1, "R4 small pass");
        step(37'h0_7FFF_FFFE, 37'd1, 1'b1, 2'd0, 1'b1, "R4 max in range");
        step(37'h0_7FFF_FFFF, 37'd1, 1'b1, 2'd0, 1'b1, "R2 just over");
        step(37'h0_FFFF_FFFF, 37'h0_FFFF_FFFF, 1'b1, 2'd0, 1'b1, "R2 large");
        step(37'h1F_8000_0000, 37'd0, 1'b1, 2'd0, 1'b1, "R4 min in range");
        step(37'h1F_8000_0000, 37'h1F_FFFF_FFFF, 1'b1, 2'd0, 1'b1, "R3 just under");
        step(37'h10_0000_0000, 37'h10_0000_0000, 1'b1, 2'd0, 1'b1, "R1 carry out wraps");
        step(37'h10_0000_0000, 37'd3, 1'b1, 2'd0, 1'b1, "R3 most negative");
        step(37'h1F_FFFF_FFFF, 37'h1F_FFFF_FFFF, 1'b1, 2'd0, 1'b1, "R4 minus two");
        step(37'h1F_FFFF_FFFF, 37'd1, 1'b1, 2'd0, 1'b1, "R1 wrap to zero");
        step(37'h0_7FFF_FFFF, 37'd1, 1'b0, 2'd0, 1'b1, "R5 pos over disabled");
        step(37'h1F_8000_0000, 37'h1F_FFFF_FFFF, 1'b0, 2'd0, 1'b1, "R5 neg over disabled");
        for (int f = 0; f < 4; f++) begin
            step(37'h0_1234_5678, 37'd0, 1'b1, 2'(f), 1'b1, "R7 lane pass");
            step(37'h0_7FFF_FFFF, 37'd9, 1'b1, 2'(f), 1'b1, "R7 lane pos clamp");
            step(37'h1F_0000_0000, 37'd0, 1'b1, 2'(f), 1'b1, "R7 lane neg clamp");
        end
        step(37'd100, 37'd1, 1'b1, 2'd1, 1'b0, "R8 valid low");
        step(37'd100, 37'd1, 1'b1, 2'd1, 1'b1, "R8 valid high");

        for (int i = 0; i < 400; i++) begin
            logic [36:0] ra, rb;
            ra = {$urandom, $urandom} & 37'h1F_FFFF_FFFF;
            rb = {$urandom, $urandom} & 37'h1F_FFFF_FFFF;
            if (i % 3 == 1) begin
                ra = {{6{ra[31]}}, ra[30:0]};
                rb = {{6{rb[31]}}, rb[30:0]};
            end
            step(ra, rb, 1'($urandom), 2'($urandom), 1'($urandom), "R2/R3/R4 random");
        end

        // R9: synchronous reset mid-stream clears the outputs
        step(37'h0_7FFF_FFFF, 37'd5, 1'b1, 2'd0, 1'b1, "R2 before reset");
        @(negedge clk);
        compare_pending();
        pend = 0;
        op_a = 37'h0_7FFF_FFFF; op_b = 37'd5; sat_en = 1'b1; in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R9", "mid reset wr_word", wr_word, 32'h0);
        check("R9", "mid reset sat_flag", {31'd0, sat_flag}, 32'h0);
        check("R9", "mid reset out_valid", {31'd0, out_valid}, 32'h0);
        rst = 1'b0;

        step(37'd1, 37'd2, 1'b1, 2'd2, 1'b1, "R9 after reset");
        step(37'd0, 37'd0, 1'b0, 2'd0, 1'b0, "R8 idle");
        @(negedge clk);
        compare_pending();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule